// File: doc/BRIEF.md
# Multichannel ADC Window-Compare Controller

This block is the digital front end of an external successive-approximation converter. Software programs it through a plain 32-bit register port. While it runs, the block paces conversions with a programmable divider. It scans the enabled channels in round-robin order and keeps the most recent 12-bit code of every channel. Each code is checked against a per-channel window made of a low and a high threshold.

Three interrupt banks report per-channel events: data-ready, below-window and above-window. Each bank has its own enable bits and write-one-to-clear status bits. One combined interrupt line is the OR of every enabled, pending status bit. The two window interrupts are independent of each other, so a resistor-ladder key can be seen going down by a low event and coming back up by a high event.

The scan sequencer is a four-state machine:
- `SC_IDLE` moves to `SC_WAIT` when the block is running and at least one channel is enabled.
- `SC_WAIT` returns to `SC_IDLE` when that condition drops. On a pacing tick it moves to `SC_ISSUE`.
- `SC_ISSUE` raises the converter request for one cycle and always moves to `SC_BUSY`.
- `SC_BUSY` waits for the converter's done strobe, stores the result and returns to `SC_WAIT`.

Top module: `adc_window_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `conv_req` stays low.
- R2: Conversions are requested only while CTRL (0x00) bit 0 is 1 and CTRL[19:18] is 2'b10 (continuous). `conv_req` lasts one cycle. `conv_ch` names only channels whose bit n in CHSEL (0x08) is set. Successive requests visit the enabled channels in ascending order and wrap around.
- R3: The divider is RATE[31:16] (0x04) and the other RATE bits read zero. While conversions finish within a period, successive requests are exactly divider+1 clock cycles apart.
- R4: The result word of channel n is at 0x80+4n. It holds the last completed code in bits 11:0, and its other bits read zero. A conversion changes only the word of its own channel.
- R5: The window word of channel n is at 0x40+4n. It holds the low threshold in bits 11:0 and the high threshold in bits 27:16, and all other bits read zero.
- R6: With the compare-enable bit CHSEL[16+n] set, a result strictly below the low threshold sets bit n of LOW status (0x1C). A result strictly above the high threshold sets bit n of HIGH status (0x20). A result equal to a threshold sets neither bit.
- R7: Each completed conversion sets bit n of DRDY status (0x18). With CHSEL[16+n] clear, no window event is raised for channel n.
- R8: Writing to a status register clears the bits written as one. Bits written as zero keep their value.
- R9: When a clear write and a new event hit the same status bit in the same cycle, the bit ends up set.
- R10: Status bits latch whether or not they are enabled. `irq` is the OR, over the three banks, of status ANDed with the bank's enable register (DRDY 0x0C, LOW 0x10, HIGH 0x14).
- R11: CTRL reads back its enable bit 0, its calibration bit 1 and its mode field 19:18. All other CTRL bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high (with bus_sel) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | 2 | Channel of the current conversion |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 12 | Converter result code |
| irq | output | 1 | Combined interrupt |

## Verification
Some properties are checked on every cycle by assertions:
- a request lasts one cycle and names an enabled channel;
- the gap between pacing ticks never exceeds divider+1;
- every accepted result lands in its own channel's word;
- a below-window result with compare enabled latches its status bit;
- a set always beats a clear;
- a status bank with nothing written and nothing set holds still.

Other behaviour can only be shown by the bench's scenarios:
- exact request spacing and the round-robin order across gaps in the enable mask;
- the window sweep at and around both thresholds;
- the mode gating;
- partial clears;
- the interrupt-enable masking.

// File: rtl/adc_wc_pkg.sv
package adc_wc_pkg;

    localparam int RES_W  = 12;
    localparam int NBANK  = 3;

    localparam int BANK_DRDY = 0;
    localparam int BANK_LOW  = 1;
    localparam int BANK_HIGH = 2;

    localparam logic [1:0] MODE_CONT = 2'b10;

    localparam logic [7:0] OFS_CTRL     = 8'h00;
    localparam logic [7:0] OFS_RATE     = 8'h04;
    localparam logic [7:0] OFS_CHSEL    = 8'h08;
    localparam logic [7:0] OFS_IEN0     = 8'h0C;
    localparam logic [7:0] OFS_STS0     = 8'h18;
    localparam logic [7:0] OFS_WIN0     = 8'h40;
    localparam logic [7:0] OFS_RES0     = 8'h80;

    localparam int RATE_LSB  = 16;
    localparam int CMPEN_LSB = 16;
    localparam int HIGH_LSB  = 16;
    localparam int MODE_LSB  = 18;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_WAIT  = 2'd1,
        SC_ISSUE = 2'd2,
        SC_BUSY  = 2'd3
    } scan_state_e;

endpackage

// File: rtl/adc_wc_pacer.sv
module adc_wc_pacer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q >= div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q >= div);

    // Checker state: cycles since the previous tick, saturating.
    logic [DIV_W:0] gap_q;
    logic           seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (!run) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (tick) begin
            gap_q  <= (DIV_W+1)'(1);
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen_q) |-> (gap_q <= ({1'b0, div} + 1'b1)))
        else $error("R3: pacing tick later than divider+1 cycles");

endmodule

// File: rtl/adc_wc_scan.sv
module adc_wc_scan
    import adc_wc_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [NCH-1:0]   chan_en,
    input  logic             tick,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             conv_req,
    output logic [CH_W-1:0]  conv_ch,
    output logic             res_we,
    output logic [CH_W-1:0]  res_ch,
    output logic [RES_W-1:0] res_data
);

    scan_state_e     state_q, state_d;
    logic [CH_W-1:0] cur_q;
    logic            active;

    function automatic logic [CH_W-1:0] pick_next(input logic [CH_W-1:0] from,
                                                  input logic [NCH-1:0]  en);
        logic [CH_W-1:0] r;
        logic            hit;
        r   = from;
        hit = 1'b0;
        for (int k = 1; k <= NCH; k++) begin
            int idx;
            idx = (int'(from) + k) % NCH;
            if (!hit && en[idx]) begin
                r   = CH_W'(idx);
                hit = 1'b1;
            end
        end
        return r;
    endfunction

    assign active = run && (chan_en != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE:  if (active) state_d = SC_WAIT;
            SC_WAIT: begin
                if (!active)   state_d = SC_IDLE;
                else if (tick) state_d = SC_ISSUE;
            end
            SC_ISSUE: state_d = SC_BUSY;
            SC_BUSY:  if (conv_done) state_d = SC_WAIT;
            default:  state_d = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            cur_q   <= CH_W'(NCH - 1);
        end else begin
            state_q <= state_d;
            if (state_q == SC_WAIT && active && tick) begin
                cur_q <= pick_next(cur_q, chan_en);
            end
        end
    end

    always_comb begin
        conv_req = (state_q == SC_ISSUE);
        conv_ch  = cur_q;
        res_we   = (state_q == SC_BUSY) && conv_done;
        res_ch   = cur_q;
        res_data = conv_data;
    end

    p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req)
        else $error("R2: request longer than one cycle");

    p_req_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> chan_en[conv_ch])
        else $error("R2: request for a disabled channel");

endmodule

// File: rtl/adc_wc_evt_bank.sv
module adc_wc_evt_bank #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set,
    input  logic           clr_we,
    input  logic [NCH-1:0] clr_mask,
    input  logic [NCH-1:0] ien,
    output logic [NCH-1:0] sts,
    output logic           irq
);

    logic [NCH-1:0] kill;

    assign kill = clr_we ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts <= (sts & ~kill) | set;
        end
    end

    assign irq = |(sts & ien);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((sts & $past(set)) == $past(set)))
        else $error("R9: event lost against a clear");

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((clr_mask & ~set) != '0)) |=> ((sts & $past(clr_mask & ~set)) == '0))
        else $error("R8: written-one bit not cleared");

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && set == '0) |=> $stable(sts))
        else $error("R8: status changed without cause");

endmodule

// File: rtl/adc_window_ctrl.sv
module adc_window_ctrl
    import adc_wc_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DIV_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [7:0]               bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     conv_req,
    output logic [$clog2(NCH)-1:0]   conv_ch,
    input  logic                     conv_done,
    input  logic [RES_W-1:0]         conv_data,
    output logic                     irq
);

    localparam int CH_W = $clog2(NCH);

    logic             ctrl_en_q, ctrl_cal_q;
    logic [1:0]       ctrl_mode_q;
    logic [DIV_W-1:0] div_q;
    logic [NCH-1:0]   ch_en_q, cmp_en_q;
    logic [NCH-1:0]   ien_q   [NBANK];
    logic [NCH-1:0]   sts     [NBANK];
    logic [NCH-1:0]   set_v   [NBANK];
    logic             clr_we  [NBANK];
    logic [NBANK-1:0] bank_irq;
    logic [RES_W-1:0] lo_q    [NCH];
    logic [RES_W-1:0] hi_q    [NCH];
    logic [RES_W-1:0] data_q  [NCH];

    logic             wr_en, run, tick;
    logic             res_we;
    logic [CH_W-1:0]  res_ch;
    logic [RES_W-1:0] res_data;

    assign wr_en = bus_sel && bus_wr;
    assign run   = ctrl_en_q && (ctrl_mode_q == MODE_CONT);

    // Global configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en_q   <= 1'b0;
            ctrl_cal_q  <= 1'b0;
            ctrl_mode_q <= 2'b00;
            div_q       <= '0;
            ch_en_q     <= '0;
            cmp_en_q    <= '0;
        end else if (wr_en) begin
            if (bus_addr == OFS_CTRL) begin
                ctrl_en_q   <= bus_wdata[0];
                ctrl_cal_q  <= bus_wdata[1];
                ctrl_mode_q <= bus_wdata[MODE_LSB +: 2];
            end
            if (bus_addr == OFS_RATE) begin
                div_q <= bus_wdata[RATE_LSB +: DIV_W];
            end
            if (bus_addr == OFS_CHSEL) begin
                ch_en_q  <= bus_wdata[NCH-1:0];
                cmp_en_q <= bus_wdata[CMPEN_LSB +: NCH];
            end
        end
    end

    // Interrupt banks: enables, event sources, status
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ien_q[b] <= '0;
            end else if (wr_en && bus_addr == (OFS_IEN0 + 8'(4 * b))) begin
                ien_q[b] <= bus_wdata[NCH-1:0];
            end
        end

        assign clr_we[b] = wr_en && (bus_addr == (OFS_STS0 + 8'(4 * b)));

        adc_wc_evt_bank #(.NCH(NCH)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set      (set_v[b]),
            .clr_we   (clr_we[b]),
            .clr_mask (bus_wdata[NCH-1:0]),
            .ien      (ien_q[b]),
            .sts      (sts[b]),
            .irq      (bank_irq[b])
        );
    end

    // Per-channel window registers, result registers and comparators
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = res_we && (res_ch == CH_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end else if (wr_en && bus_addr == (OFS_WIN0 + 8'(4 * i))) begin
                lo_q[i] <= bus_wdata[RES_W-1:0];
                hi_q[i] <= bus_wdata[HIGH_LSB +: RES_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[i] <= '0;
            end else if (hit) begin
                data_q[i] <= res_data;
            end
        end

        assign set_v[BANK_DRDY][i] = hit;
        assign set_v[BANK_LOW][i]  = hit && cmp_en_q[i] && (res_data < lo_q[i]);
        assign set_v[BANK_HIGH][i] = hit && cmp_en_q[i] && (res_data > hi_q[i]);
    end

    assign irq = |bank_irq;

    adc_wc_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_q),
        .tick  (tick)
    );

    adc_wc_scan #(.NCH(NCH), .CH_W(CH_W)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .chan_en   (ch_en_q),
        .tick      (tick),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .conv_req  (conv_req),
        .conv_ch   (conv_ch),
        .res_we    (res_we),
        .res_ch    (res_ch),
        .res_data  (res_data)
    );

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CTRL) begin
            bus_rdata[0]             = ctrl_en_q;
            bus_rdata[1]             = ctrl_cal_q;
            bus_rdata[MODE_LSB +: 2] = ctrl_mode_q;
        end
        if (bus_addr == OFS_RATE) begin
            bus_rdata[RATE_LSB +: DIV_W] = div_q;
        end
        if (bus_addr == OFS_CHSEL) begin
            bus_rdata[NCH-1:0]         = ch_en_q;
            bus_rdata[CMPEN_LSB +: NCH] = cmp_en_q;
        end
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr == (OFS_IEN0 + 8'(4 * b))) bus_rdata[NCH-1:0] = ien_q[b];
            if (bus_addr == (OFS_STS0 + 8'(4 * b))) bus_rdata[NCH-1:0] = sts[b];
        end
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == (OFS_WIN0 + 8'(4 * i))) begin
                bus_rdata[RES_W-1:0]          = lo_q[i];
                bus_rdata[HIGH_LSB +: RES_W]  = hi_q[i];
            end
            if (bus_addr == (OFS_RES0 + 8'(4 * i))) begin
                bus_rdata[RES_W-1:0] = data_q[i];
            end
        end
    end

    p_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |=> (data_q[$past(res_ch)] == $past(res_data)))
        else $error("R4: result not stored in its channel word");

    p_low_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && cmp_en_q[res_ch] && (res_data < lo_q[res_ch])) |=> sts[BANK_LOW][$past(res_ch)])
        else $error("R6: below-window result did not latch");

    p_no_req_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> !conv_req)
        else $error("R2: request while not running");

    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q[0] == '0 && ien_q[1] == '0 && ien_q[2] == '0) |-> !irq)
        else $error("R10: interrupt with every enable clear");

endmodule

// File: tb/sim_adc_window_ctrl.sv
module sim_adc_window_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int DIVV = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_req;
    logic [1:0]  conv_ch;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        irq;

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    int done_cnt = 0;
    int req_n = 0;
    int req_cyc [256];
    int req_chv [256];
    logic [11:0] model_val [NCH];

    adc_window_ctrl #(.NCH(NCH), .DIV_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done),
        .conv_data(conv_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_dones(input int k);
        int base;
        base = done_cnt;
        wait (done_cnt >= base + k);
    endtask

    function automatic int rr_next(input int prev, input logic [3:0] en);
        for (int k = 1; k <= NCH; k++) begin
            if (en[(prev + k) % NCH]) return (prev + k) % NCH;
        end
        return prev;
    endfunction

    // Converter model: answers every request two cycles later
    initial begin
        for (int i = 0; i < NCH; i++) model_val[i] = '0;
        forever begin
            @(negedge clk);
            if (conv_req) begin
                int ch;
                ch = int'(conv_ch);
                if (req_n < 256) begin
                    req_cyc[req_n] = cyc;
                    req_chv[req_n] = ch;
                end
                req_n++;
                @(negedge clk);
                @(negedge clk);
                conv_done = 1'b1;
                conv_data = model_val[ch];
                done_cnt++;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int lo_t [5];
        int hi_t [5];
        int r0;
        lo_t = '{100, 0, 2048, 4095, 1};
        hi_t = '{200, 4095, 2048, 0, 4094};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
        rd(8'h08, d); chk("R1 chsel", d, 32'h0);
        rd(8'h1C, d); chk("R1 low sts", d, 32'h0);
        rd(8'h84, d); chk("R1 result ch1", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        repeat (20) @(negedge clk);
        chk("R1 no request", req_n, 0);

        // R11 control readback, R3 rate field, R5 window packing
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R11 ctrl all ones", d, 32'h000C_0003);
        wr(8'h00, 32'h0004_0002); rd(8'h00, d); chk("R11 ctrl cal+mode", d, 32'h0004_0002);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R3 rate readback", d, 32'hFFFF_0000);
        wr(8'h48, 32'hFFFF_FFFF); rd(8'h48, d); chk("R5 window ch2", d, 32'h0FFF_0FFF);
        wr(8'h48, 32'h0123_0456); rd(8'h48, d); chk("R5 window fields", d, 32'h0123_0456);

        // R2 mode gating
        wr(8'h04, DIVV << 16);
        wr(8'h08, 32'h0001_0001);
        wr(8'h00, 32'h0004_0001);
        repeat (60) @(negedge clk);
        chk("R2 non-continuous mode idle", req_n, 0);
        wr(8'h00, 32'h0008_0000);
        repeat (60) @(negedge clk);
        chk("R2 enable clear idle", req_n, 0);

        // R6/R4/R7/R10 window sweep on channel 0
        wr(8'h00, 32'h0008_0001);
        for (int p = 0; p < 5; p++) begin
            int vals [8];
            int lo, hi;
            lo = lo_t[p]; hi = hi_t[p];
            wr(8'h40, 32'((hi << 16) | lo));
            vals = '{0, (lo == 0) ? 0 : lo - 1, lo, (lo == 4095) ? 4095 : lo + 1,
                     (hi == 0) ? 0 : hi - 1, hi, (hi == 4095) ? 4095 : hi + 1, 4095};
            for (int j = 0; j < 8; j++) begin
                model_val[0] = 12'(vals[j]);
                wait_dones(1);
                @(negedge clk);
                rd(8'h80, d); chk("R4 result word", d, 32'(vals[j]));
                rd(8'h1C, d); chk("R6 low event", d, {31'b0, vals[j] < lo});
                rd(8'h20, d); chk("R6 high event", d, {31'b0, vals[j] > hi});
                rd(8'h18, d); chk("R7 data ready", d, 32'h1);
                chk("R10 masked irq", {31'b0, irq}, 32'h0);
                wr(8'h18, 32'hFFFF_FFFF);
                wr(8'h1C, 32'hFFFF_FFFF);
                wr(8'h20, 32'hFFFF_FFFF);
            end
        end
        wr(8'h00, 32'h0);
        repeat (20) @(negedge clk);
        wr(8'h18, 32'hF); wr(8'h1C, 32'hF); wr(8'h20, 32'hF);

        // R2/R3 round robin over channels 0,2,3
        for (int i = 0; i < NCH; i++) begin
            wr(8'(8'h40 + 4 * i), 32'h0FFF_0064);
            model_val[i] = 12'(i);
        end
        wr(8'h08, 32'h000F_000D);
        r0 = req_n;
        wr(8'h00, 32'h0008_0001);
        wait_dones(6);
        wr(8'h00, 32'h0);
        repeat (20) @(negedge clk);
        chk("R2 first channel enabled", {31'b0, (4'b1101 >> req_chv[r0]) & 1'b1 ? 1'b1 : 1'b0}, 32'h1);
        for (int k = r0 + 1; k < r0 + 6; k++) begin
            chk("R2 round robin order", req_chv[k], rr_next(req_chv[k-1], 4'b1101));
            chk("R3 request spacing", req_cyc[k] - req_cyc[k-1], DIVV + 1);
        end
        rd(8'h1C, d); chk("R6 low bank multi", d, 32'hD);
        rd(8'h18, d); chk("R7 drdy bank multi", d, 32'hD);
        rd(8'h20, d); chk("R6 high bank multi", d, 32'h0);
        rd(8'h84, d); chk("R4 ch1 untouched", d, 32'h0);
        rd(8'h88, d); chk("R4 ch2 result", d, 32'h2);
        rd(8'h8C, d); chk("R4 ch3 result", d, 32'h3);

        // R8 partial clear
        wr(8'h1C, 32'h5); rd(8'h1C, d); chk("R8 partial clear", d, 32'h8);
        wr(8'h18, 32'h0); rd(8'h18, d); chk("R8 zero write keeps", d, 32'hD);

        // R10 interrupt masking
        wr(8'h10, 32'h2); rd(8'h10, d); chk("R10 ien readback", d, 32'h2);
        chk("R10 enable on clear bit", {31'b0, irq}, 32'h0);
        wr(8'h10, 32'h8); chk("R10 enabled pending", {31'b0, irq}, 32'h1);
        wr(8'h1C, 32'hF); chk("R10 cleared", {31'b0, irq}, 32'h0);
        wr(8'h0C, 32'h1); chk("R10 drdy bank", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h0); wr(8'h10, 32'h0);
        wr(8'h18, 32'hF);

        // R7 compare disabled
        model_val[0] = 12'd5;
        wr(8'h08, 32'h0000_0001);
        wr(8'h00, 32'h0008_0001);
        wait_dones(1);
        @(negedge clk);
        wr(8'h00, 32'h0);
        rd(8'h1C, d); chk("R7 no low without compare", d, 32'h0);
        rd(8'h18, d); chk("R7 drdy without compare", d, 32'h1);
        rd(8'h80, d); chk("R7 result stored", d, 32'h5);
        repeat (20) @(negedge clk);
        wr(8'h18, 32'hF);

        // R9 clear and event in the same cycle
        model_val[0] = 12'd7;
        wr(8'h08, 32'h0001_0001);
        wr(8'h00, 32'h0008_0001);
        begin
            int base;
            base = done_cnt;
            wait (done_cnt != base);
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'hFFFF_FFFF;
            @(posedge clk);
            #1;
            bus_sel = 1'b0; bus_wr = 1'b0;
        end
        rd(8'h1C, d); chk("R9 set beats clear", d, 32'h1);
        wr(8'h00, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule